// File: doc/BRIEF.md
# NAND Page Column Pointer

This block tracks the starting column inside a 528-byte flash page when the upper column bits are not sent as an address cycle. Instead, three read commands pick one of three areas: the lower half of the main field (columns 0 to 255), the upper half (columns 256 to 511), or the 16-byte spare field (columns 512 to 527). The selected area is combined with the single 8-bit column address byte to form the start column. A read strobe then steps that column forward one byte at a time until the page ends.

The block sits between a command decoder and the page-register column counter. The lower-half and spare selections stay in force until they are replaced. The upper-half selection lasts for one operation only: once its address byte has been used, the pointer falls back to the lower half. A reset command returns the pointer and the column to their start-up values.

Top module: `nand_col_pointer`

## Requirements
- R1: After synchronous reset, `area_sel` is 0, `col_idx` is 0 and `page_end` is 0. The area code is 0 for the lower half, 1 for the upper half and 2 for the spare field.
- R2: Command 8'h00 selects area 0, and that selection persists. An address byte then loads `col_idx` with the byte value, and `area_sel` stays 0 afterwards.
- R3: Command 8'h01 selects area 1. The next address byte loads `col_idx` with 256 plus the byte, and `area_sel` returns to 0 in the same cycle. A following address byte loads the byte value alone.
- R4: Command 8'h50 selects area 2, and that selection persists. An address byte loads `col_idx` with 512 plus bits [3:0] of the byte; bits [7:4] are ignored.
- R5: Each accepted `rd_advance` raises `col_idx` by one while `col_idx` is below 527.
- R6: An accepted `rd_advance` at column 527 has two effects. It raises `page_end` for exactly one cycle, and it reloads `col_idx` with the base of the current area (0, 256 or 512).
- R7: Command 8'hFF sets `area_sel` to 0 and `col_idx` to 0.
- R8: Any other command code leaves `area_sel` and `col_idx` unchanged.
- R9: When inputs arrive in the same cycle, a command wins over an address byte and a read strobe, and an address byte wins over a read strobe. The losing inputs have no effect.
- R10: All outputs are registered. They change on the clock edge after the input that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command code is presented this cycle |
| cmd_code | input | 8 | Command code |
| addr_valid | input | 1 | A column address byte is presented this cycle |
| addr_byte | input | 8 | Column address byte |
| rd_advance | input | 1 | One byte has been read; step the column |
| col_idx | output | 10 | Current column, 0 to 527 |
| area_sel | output | 2 | Current pointer area code |
| page_end | output | 1 | One-cycle strobe after the last spare byte is read |

## Verification
Several properties are checked on every cycle by the assertions. They confirm that the column never leaves the page, and that a read strobe below the last column adds exactly one. They also confirm that the end strobe never lasts two cycles, that an address byte taken in the upper half returns the pointer to the lower half, and that the spare command lands on area 2. Other behaviour only the bench scenarios can show. These are the exact start columns formed from each area and byte, the masking of the upper byte bits in the spare field, and the reload base after a wrap in each area. The same holds for the effect of the reset command, the neutrality of unknown commands, and which input wins when several arrive together.

// File: rtl/nand_ptr_pkg.sv
package nand_ptr_pkg;

  typedef enum logic [1:0] {
    AREA_LOW   = 2'd0,
    AREA_HIGH  = 2'd1,
    AREA_SPARE = 2'd2
  } area_e;

  localparam logic [7:0] CMD_SEL_LOW   = 8'h00;
  localparam logic [7:0] CMD_SEL_HIGH  = 8'h01;
  localparam logic [7:0] CMD_SEL_SPARE = 8'h50;
  localparam logic [7:0] CMD_RESET     = 8'hFF;

endpackage

// File: rtl/ptr_cmd_decode.sv
module ptr_cmd_decode
  import nand_ptr_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       sel_valid,
  output area_e      sel_area,
  output logic       rst_cmd
);

  always_comb begin
    sel_valid = 1'b0;
    sel_area  = AREA_LOW;
    rst_cmd   = 1'b0;
    if (cmd_valid) begin
      case (cmd_code)
        CMD_SEL_LOW: begin
          sel_valid = 1'b1;
          sel_area  = AREA_LOW;
        end
        CMD_SEL_HIGH: begin
          sel_valid = 1'b1;
          sel_area  = AREA_HIGH;
        end
        CMD_SEL_SPARE: begin
          sel_valid = 1'b1;
          sel_area  = AREA_SPARE;
        end
        CMD_RESET: begin
          sel_valid = 1'b1;
          sel_area  = AREA_LOW;
          rst_cmd   = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ptr_area_reg.sv
module ptr_area_reg
  import nand_ptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sel_valid,
  input  area_e sel_area,
  input  logic  consume,
  output area_e area_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      area_q <= AREA_LOW;
    end else if (sel_valid) begin
      area_q <= sel_area;
    end else if (consume && area_q == AREA_HIGH) begin
      area_q <= AREA_LOW;
    end
  end

  // R3: the upper-half pointer lasts for one address load only
  a_r3_high_reverts : assert property (@(posedge clk) disable iff (rst)
    (consume && !sel_valid && area_q == AREA_HIGH) |=> (area_q == AREA_LOW));

  // R4: the spare selection lands on area code 2
  a_r4_spare_select : assert property (@(posedge clk) disable iff (rst)
    (sel_valid && sel_area == AREA_SPARE) |=> (area_q == AREA_SPARE));

  // R2: a persistent selection is not disturbed by an address load
  a_r2_low_sticky : assert property (@(posedge clk) disable iff (rst)
    (!sel_valid && area_q != AREA_HIGH) |=> $stable(area_q));

endmodule

// File: rtl/ptr_col_counter.sv
module ptr_col_counter
  import nand_ptr_pkg::*;
#(
  parameter int HALF_COLS  = 256,
  parameter int SPARE_COLS = 16,
  parameter int ADDR_W     = $clog2(HALF_COLS),
  parameter int COL_W      = $clog2(2 * HALF_COLS + SPARE_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_byte,
  input  area_e             area,
  input  logic              adv,
  output logic [COL_W-1:0]  col_q,
  output logic              page_end_q
);

  localparam int SPARE_W   = $clog2(SPARE_COLS);
  localparam int PAGE_COLS = 2 * HALF_COLS + SPARE_COLS;
  localparam logic [COL_W-1:0] LAST_COL   = COL_W'(PAGE_COLS - 1);
  localparam logic [COL_W-1:0] BASE_HIGH  = COL_W'(HALF_COLS);
  localparam logic [COL_W-1:0] BASE_SPARE = COL_W'(2 * HALF_COLS);

  logic [COL_W-1:0] base;
  logic [COL_W-1:0] offset;
  logic             at_last;

  always_comb begin
    case (area)
      AREA_HIGH:  base = BASE_HIGH;
      AREA_SPARE: base = BASE_SPARE;
      default:    base = '0;
    endcase
  end

  // spare field keeps only the low bits of the byte
  always_comb begin
    if (area == AREA_SPARE)
      offset = {{(COL_W-SPARE_W){1'b0}}, load_byte[SPARE_W-1:0]};
    else
      offset = {{(COL_W-ADDR_W){1'b0}}, load_byte};
  end

  assign at_last = (col_q == LAST_COL);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q      <= '0;
      page_end_q <= 1'b0;
    end else begin
      page_end_q <= 1'b0;
      if (clear) begin
        col_q <= '0;
      end else if (load) begin
        col_q <= base + offset;
      end else if (adv) begin
        if (at_last) begin
          col_q      <= base;
          page_end_q <= 1'b1;
        end else begin
          col_q <= col_q + COL_W'(1);
        end
      end
    end
  end

  // R5: a strobe below the last column adds exactly one
  a_r5_step_one : assert property (@(posedge clk) disable iff (rst)
    (adv && !clear && !load && col_q != LAST_COL) |=> (col_q == $past(col_q) + COL_W'(1)));

  // R6: the end strobe is a single-cycle pulse
  a_r6_single_pulse : assert property (@(posedge clk) disable iff (rst)
    page_end_q |=> !page_end_q);

  // R4: the column never leaves the page
  a_r4_in_page : assert property (@(posedge clk) disable iff (rst)
    col_q <= LAST_COL);

endmodule

// File: rtl/nand_col_pointer.sv
module nand_col_pointer
  import nand_ptr_pkg::*;
#(
  parameter int HALF_COLS  = 256,
  parameter int SPARE_COLS = 16,
  parameter int ADDR_W     = $clog2(HALF_COLS),
  parameter int COL_W      = $clog2(2 * HALF_COLS + SPARE_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_byte,
  input  logic              rd_advance,
  output logic [COL_W-1:0]  col_idx,
  output logic [1:0]        area_sel,
  output logic              page_end
);

  logic  sel_valid;
  area_e sel_area;
  logic  rst_cmd;
  area_e area_q;
  logic  load_en;
  logic  adv_en;
  logic  clear_en;

  // R9: command beats address, address beats read strobe
  assign load_en  = addr_valid && !cmd_valid;
  assign adv_en   = rd_advance && !cmd_valid && !addr_valid;
  assign clear_en = rst_cmd;

  ptr_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .sel_valid (sel_valid),
    .sel_area  (sel_area),
    .rst_cmd   (rst_cmd)
  );

  ptr_area_reg u_area (
    .clk       (clk),
    .rst       (rst),
    .sel_valid (sel_valid),
    .sel_area  (sel_area),
    .consume   (load_en),
    .area_q    (area_q)
  );

  ptr_col_counter #(
    .HALF_COLS  (HALF_COLS),
    .SPARE_COLS (SPARE_COLS),
    .ADDR_W     (ADDR_W),
    .COL_W      (COL_W)
  ) u_col (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear_en),
    .load       (load_en),
    .load_byte  (addr_byte),
    .area       (area_q),
    .adv        (adv_en),
    .col_q      (col_idx),
    .page_end_q (page_end)
  );

  assign area_sel = area_q;

endmodule

// File: tb/nand_col_pointer_bench.sv
module nand_col_pointer_bench;

  typedef struct {
    int    col;
    int    area;
    logic  pe;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic       addr_valid = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic       rd_advance = 1'b0;
  logic [9:0] col_idx;
  logic [1:0] area_sel;
  logic       page_end;

  int   checks = 0;
  int   failures = 0;
  int   m_area = 0;
  int   m_col = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  nand_col_pointer u_nand_col_pointer (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .addr_valid (addr_valid),
    .addr_byte  (addr_byte),
    .rd_advance (rd_advance),
    .col_idx    (col_idx),
    .area_sel   (area_sel),
    .page_end   (page_end)
  );

  function automatic int area_base(input int a);
    if (a == 1) return 256;
    if (a == 2) return 512;
    return 0;
  endfunction

  // driver: present one cycle of inputs and push the expected outputs
  task automatic step(input logic cv, input logic [7:0] cc, input logic av,
                      input logic [7:0] ab, input logic adv, input string tag);
    exp_t e;
    logic pe;
    @(negedge clk);
    cmd_valid  = cv;
    cmd_code   = cc;
    addr_valid = av;
    addr_byte  = ab;
    rd_advance = adv;
    pe = 1'b0;
    if (cv) begin
      case (cc)
        8'h00: m_area = 0;
        8'h01: m_area = 1;
        8'h50: m_area = 2;
        8'hFF: begin m_area = 0; m_col = 0; end
        default: ;
      endcase
    end else if (av) begin
      if (m_area == 2) m_col = 512 + int'(ab[3:0]);
      else m_col = area_base(m_area) + int'(ab);
      if (m_area == 1) m_area = 0;
    end else if (adv) begin
      if (m_col == 527) begin
        pe = 1'b1;
        m_col = area_base(m_area);
      end else begin
        m_col = m_col + 1;
      end
    end
    e.col  = m_col;
    e.area = m_area;
    e.pe   = pe;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, tag);
  endtask

  // monitor: compare after the edge that consumed the pushed cycle
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (int'(col_idx) != e.col || int'(area_sel) != e.area || page_end !== e.pe) begin
        failures++;
        $display("FAIL %s: col=%0d area=%0d end=%0b, expected col=%0d area=%0d end=%0b",
                 e.tag, col_idx, area_sel, page_end, e.col, e.area, e.pe);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    idle("R1");

    // R2 lower half, persistent
    step(1, 8'h00, 0, 8'h00, 0, "R2");
    step(0, 8'h00, 1, 8'h37, 0, "R2");
    step(0, 8'h00, 1, 8'h10, 0, "R2");

    // R3 upper half for one load, then back to lower half
    step(1, 8'h01, 0, 8'h00, 0, "R3");
    step(0, 8'h00, 1, 8'h05, 0, "R3");
    step(0, 8'h00, 1, 8'h05, 0, "R3");

    // R4 spare field, upper byte bits ignored, persistent
    step(1, 8'h50, 0, 8'h00, 0, "R4");
    step(0, 8'h00, 1, 8'hA7, 0, "R4");
    step(0, 8'h00, 1, 8'h03, 0, "R4");

    // R5 single steps, R6 wrap in spare area
    for (int i = 0; i < 13; i++) begin
      step(0, 8'h00, 0, 8'h00, 1, (m_col == 527) ? "R6" : "R5");
    end
    idle("R6");

    // R5 across the half boundary, R6 wrap in lower area
    step(1, 8'h00, 0, 8'h00, 0, "R2");
    step(0, 8'h00, 1, 8'hFE, 0, "R2");
    for (int i = 0; i < 275; i++) begin
      step(0, 8'h00, 0, 8'h00, 1, (m_col == 527) ? "R6" : "R5");
    end

    // R6 wrap with upper-half pointer still pending reloads 256
    step(1, 8'h50, 0, 8'h00, 0, "R6");
    step(0, 8'h00, 1, 8'h0E, 0, "R6");
    step(1, 8'h01, 0, 8'h00, 0, "R6");
    for (int i = 0; i < 3; i++) begin
      step(0, 8'h00, 0, 8'h00, 1, (m_col == 527) ? "R6" : "R5");
    end

    // R7 reset command
    step(1, 8'h50, 0, 8'h00, 0, "R7");
    step(0, 8'h00, 1, 8'h09, 0, "R7");
    step(1, 8'hFF, 0, 8'h00, 0, "R7");

    // R8 unknown commands have no effect
    step(1, 8'h50, 0, 8'h00, 0, "R8");
    step(0, 8'h00, 1, 8'h04, 0, "R8");
    step(1, 8'h90, 0, 8'h00, 0, "R8");
    step(1, 8'h70, 0, 8'h00, 0, "R8");
    step(1, 8'h02, 0, 8'h00, 0, "R8");

    // R9 precedence
    step(1, 8'h01, 1, 8'h22, 1, "R9");
    step(0, 8'h00, 1, 8'h22, 1, "R9");
    step(1, 8'hFF, 1, 8'h40, 1, "R9");

    // R10 outputs hold with no input
    idle("R10");
    idle("R10");

    @(negedge clk);
    cmd_valid  = 1'b0;
    addr_valid = 1'b0;
    rd_advance = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule